// File: doc/BRIEF.md
# Next Program Counter Calculator

This block works out where an 8-bit microcontroller core fetches next. Each cycle that `in_valid` is high, it takes the address of the current instruction, that instruction's length in bytes, a transfer kind, an encoded target field and a condition flag. On the next clock edge it registers the resulting program counter. The condition is evaluated elsewhere and arrives as an input. All arithmetic first moves the PC past the current instruction. An in-page jump then replaces only the low 11 bits. A long jump replaces the whole PC. A relative branch adds a signed 8-bit displacement.

The same advanced PC also feeds a second registered output. This is the address used by a PC-based table read, which adds the unsigned accumulator to the advanced PC. Instruction fetch, decode and the call/return stack sit outside this block.

Top module: `npc_calc`

## Requirements
- R1: While `rst_n` is low, `nxt_pc`, `tbl_addr` and `out_valid` are all zero.
- R2: The advanced PC is `cur_pc + instr_len` modulo 2^16. With `kind` = 0 (sequential), `nxt_pc` becomes the advanced PC one clock after `in_valid`.
- R3: With `kind` = 1 (in-page jump) and `take` = 1, `nxt_pc` = {advanced PC bits 15..11, `target` bits 10..0}. The region bits come from the advanced PC, so a jump whose last byte ends a 2 KB region lands in the following region.
- R4: With `kind` = 2 (long jump) and `take` = 1, `nxt_pc` equals all 16 bits of `target`.
- R5: With `kind` = 3 (relative) and `take` = 1, `nxt_pc` = advanced PC + `target` bits 7..0 sign-extended to 16 bits, modulo 2^16.
- R6: With `kind` of 1, 2 or 3 and `take` = 0, `nxt_pc` is the advanced PC.
- R7: With `kind` = 0, `take` has no effect on `nxt_pc`.
- R8: `tbl_addr` = advanced PC + zero-extended `acc`, modulo 2^16, registered with the same one-clock latency.
- R9: `out_valid` is `in_valid` delayed by one clock. In a cycle with `in_valid` low, `nxt_pc` and `tbl_addr` keep their values.
- R10: `target` bits 15..11 do not affect an in-page jump, and bits 15..8 do not affect a relative branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Current instruction length in bytes |
| kind | input | 2 | 0 sequential, 1 in-page, 2 long, 3 relative |
| target | input | 16 | Encoded destination field |
| take | input | 1 | Branch condition result |
| acc | input | 8 | Accumulator for the table read |
| nxt_pc | output | 16 | Registered next PC |
| tbl_addr | output | 16 | Registered table-read address |
| out_valid | output | 1 | Result valid |

## Verification
The hardest situations to reach are those where advancing the PC itself changes the upper bits. Examples are an in-page jump sitting across a 2 KB border, and a relative branch or table read that wraps past 0xFFFF. Uniform random PCs almost never land there. Directed cases therefore place `cur_pc` a byte or two before a region edge or before the top of memory, pairing those PCs with the most negative offset and the largest accumulator value. Random requests with junk in the unused target bits then cover the general mix.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_PAGE = 2'd1,
        NPC_LONG = 2'd2,
        NPC_REL  = 2'd3
    } npc_kind_e;
endpackage

// File: rtl/npc_adv.sv
module npc_adv #(
    parameter int PC_W  = 16,
    parameter int LEN_W = 2
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [LEN_W-1:0] instr_len,
    output logic [PC_W-1:0]  adv_pc
);
    localparam int PAD_W = PC_W - LEN_W;

    always_comb begin
        adv_pc = cur_pc + {{PAD_W{1'b0}}, instr_len};
    end
endmodule

// File: rtl/npc_dest.sv
module npc_dest
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8
) (
    input  logic [PC_W-1:0] adv_pc,
    input  npc_kind_e       kind,
    input  logic [PC_W-1:0] target,
    input  logic            take,
    output logic [PC_W-1:0] dest_pc
);
    localparam int SEXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] page_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] ofs_ext;

    generate
        if (PAGE_W < PC_W) begin : g_splice
            assign page_pc = {adv_pc[PC_W-1:PAGE_W], target[PAGE_W-1:0]};
        end else begin : g_full
            assign page_pc = target;
        end
    endgenerate

    always_comb begin
        ofs_ext = {{SEXT_W{target[OFS_W-1]}}, target[OFS_W-1:0]};
        rel_pc  = adv_pc + ofs_ext;
        dest_pc = adv_pc;
        if (take) begin
            unique case (kind)
                NPC_PAGE: dest_pc = page_pc;
                NPC_LONG: dest_pc = target;
                NPC_REL:  dest_pc = rel_pc;
                default:  dest_pc = adv_pc;
            endcase
        end
    end
endmodule

// File: rtl/npc_tbl.sv
module npc_tbl #(
    parameter int PC_W  = 16,
    parameter int ACC_W = 8
) (
    input  logic [PC_W-1:0]  adv_pc,
    input  logic [ACC_W-1:0] acc,
    output logic [PC_W-1:0]  tbl_pc
);
    localparam int PAD_W = PC_W - ACC_W;

    always_comb begin
        tbl_pc = adv_pc + {{PAD_W{1'b0}}, acc};
    end
endmodule

// File: rtl/npc_calc.sv
module npc_calc
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int LEN_W  = 2,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8,
    parameter int ACC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [LEN_W-1:0] instr_len,
    input  logic [1:0]       kind,
    input  logic [PC_W-1:0]  target,
    input  logic             take,
    input  logic [ACC_W-1:0] acc,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [PC_W-1:0]  tbl_addr,
    output logic             out_valid
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] tbl;
        logic            vld;
    } npc_state_t;

    npc_state_t st_d, st_q;
    logic [PC_W-1:0] adv_pc;
    logic [PC_W-1:0] dest_pc;
    logic [PC_W-1:0] tbl_pc;
    npc_kind_e       kind_e;

    assign kind_e = npc_kind_e'(kind);

    npc_adv #(.PC_W(PC_W), .LEN_W(LEN_W)) adv_i (
        .cur_pc    (cur_pc),
        .instr_len (instr_len),
        .adv_pc    (adv_pc)
    );

    npc_dest #(.PC_W(PC_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) dest_i (
        .adv_pc  (adv_pc),
        .kind    (kind_e),
        .target  (target),
        .take    (take),
        .dest_pc (dest_pc)
    );

    npc_tbl #(.PC_W(PC_W), .ACC_W(ACC_W)) tbl_i (
        .adv_pc (adv_pc),
        .acc    (acc),
        .tbl_pc (tbl_pc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pc  = dest_pc;
            st_d.tbl = tbl_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_pc    = st_q.pc;
    assign tbl_addr  = st_q.tbl;
    assign out_valid = st_q.vld;
endmodule

// File: rtl/npc_calc_chk.sv
module npc_calc_chk #(
    parameter int PC_W   = 16,
    parameter int LEN_W  = 2,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8,
    parameter int ACC_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PC_W-1:0]  cur_pc,
    input logic [LEN_W-1:0] instr_len,
    input logic [1:0]       kind,
    input logic [PC_W-1:0]  target,
    input logic             take,
    input logic [ACC_W-1:0] acc,
    input logic [PC_W-1:0]  nxt_pc,
    input logic [PC_W-1:0]  tbl_addr,
    input logic             out_valid
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(nxt_pc) && $stable(tbl_addr) && !out_valid));

    // R4
    long_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && take && kind == 2'd2) |=> (nxt_pc == $past(target)));

    // R3
    page_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && take && kind == 2'd1) |=>
            (nxt_pc[PAGE_W-1:0] == $past(target[PAGE_W-1:0])));

    // R2
    seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd0) |=>
            (nxt_pc == $past(cur_pc) + PC_W'($past(instr_len))));

    // R6
    not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !take) |=>
            (nxt_pc == $past(cur_pc) + PC_W'($past(instr_len))));

    // R8
    tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (tbl_addr == $past(cur_pc) + PC_W'($past(instr_len))
                                   + PC_W'($past(acc))));
endmodule

bind npc_calc npc_calc_chk #(
    .PC_W(PC_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
    .instr_len(instr_len), .kind(kind), .target(target), .take(take),
    .acc(acc), .nxt_pc(nxt_pc), .tbl_addr(tbl_addr), .out_valid(out_valid)
);

// File: tb/npc_calc_tb.sv
module npc_calc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [1:0]  instr_len = '0;
    logic [1:0]  kind = '0;
    logic [15:0] target = '0;
    logic        take = 1'b0;
    logic [7:0]  acc = '0;
    logic [15:0] nxt_pc;
    logic [15:0] tbl_addr;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_calc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
        .instr_len(instr_len), .kind(kind), .target(target), .take(take),
        .acc(acc), .nxt_pc(nxt_pc), .tbl_addr(tbl_addr), .out_valid(out_valid)
    );

    function automatic logic [15:0] model_pc(input logic [15:0] pc, input logic [1:0] len,
                                             input logic [1:0] k, input logic [15:0] tg,
                                             input logic t);
        logic [15:0] a;
        a = pc + {14'd0, len};
        if (!t || k == 2'd0) return a;
        case (k)
            2'd1:    return {a[15:11], tg[10:0]};
            2'd2:    return tg;
            default: return a + {{8{tg[7]}}, tg[7:0]};
        endcase
    endfunction

    function automatic logic [15:0] model_tbl(input logic [15:0] pc, input logic [1:0] len,
                                              input logic [7:0] a);
        return pc + {14'd0, len} + {8'd0, a};
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] pc, input logic [1:0] len, input logic [1:0] k,
                         input logic [15:0] tg, input logic t, input logic [7:0] a);
        @(negedge clk);
        in_valid = 1'b1; cur_pc = pc; instr_len = len; kind = k;
        target = tg; take = t; acc = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string req, input logic [15:0] pc, input logic [1:0] len,
                       input logic [1:0] k, input logic [15:0] tg, input logic t,
                       input logic [7:0] a);
        issue(pc, len, k, tg, t, a);
        check16(req, nxt_pc, model_pc(pc, len, k, tg, t));
        check16("R8 table", tbl_addr, model_tbl(pc, len, a));
        check16("R9 valid", {15'd0, out_valid}, 16'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        in_valid = 1'b1; cur_pc = 16'h1234; instr_len = 2'd2; take = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check16("R1 nxt_pc", nxt_pc, 16'h0000);
        check16("R1 tbl_addr", tbl_addr, 16'h0000);
        check16("R1 out_valid", {15'd0, out_valid}, 16'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 sequential, including wrap past top of memory
        run("R2 seq", 16'h0100, 2'd1, 2'd0, 16'h0000, 1'b0, 8'h00);
        run("R2 seq wrap", 16'hFFFE, 2'd3, 2'd0, 16'hABCD, 1'b0, 8'h10);
        // R7 take ignored for sequential
        run("R7 seq take", 16'h2000, 2'd2, 2'd0, 16'h0055, 1'b1, 8'h00);
        check16("R7 seq take value", nxt_pc, 16'h2002);
        // R3 in-page jump crossing a 2 KB border via the advance
        run("R3 page border", 16'h07FE, 2'd2, 2'd1, 16'h0123, 1'b1, 8'h00);
        check16("R3 page border value", nxt_pc, 16'h0923);
        run("R3 page same", 16'h3456, 2'd2, 2'd1, 16'h07FF, 1'b1, 8'h00);
        // R10 upper target bits ignored for in-page jump
        run("R10 page junk", 16'h3456, 2'd2, 2'd1, 16'hF8FF, 1'b1, 8'h00);
        check16("R10 page junk value", nxt_pc, 16'h30FF);
        // R4 long jump
        run("R4 long", 16'h0010, 2'd3, 2'd2, 16'hBEEF, 1'b1, 8'h00);
        check16("R4 long value", nxt_pc, 16'hBEEF);
        // R5 relative: negative, most negative, wrap
        run("R5 rel neg", 16'h0100, 2'd2, 2'd3, 16'h00FE, 1'b1, 8'h00);
        check16("R5 rel neg value", nxt_pc, 16'h0100);
        run("R5 rel min", 16'h0010, 2'd2, 2'd3, 16'h0080, 1'b1, 8'h00);
        check16("R5 rel min value", nxt_pc, 16'hFF92);
        run("R5 rel wrap", 16'hFFFE, 2'd3, 2'd3, 16'h0005, 1'b1, 8'h00);
        check16("R5 rel wrap value", nxt_pc, 16'h0006);
        // R10 upper bits ignored for relative
        run("R10 rel junk", 16'h0200, 2'd3, 2'd3, 16'hA57F, 1'b1, 8'h00);
        check16("R10 rel junk value", nxt_pc, 16'h0282);
        // R6 not taken
        run("R6 page nt", 16'h07FE, 2'd2, 2'd1, 16'h0123, 1'b0, 8'h00);
        run("R6 long nt", 16'h4000, 2'd3, 2'd2, 16'hBEEF, 1'b0, 8'h00);
        run("R6 rel nt", 16'h4000, 2'd3, 2'd3, 16'h0080, 1'b0, 8'h00);
        check16("R6 rel nt value", nxt_pc, 16'h4003);
        // R8 table read wrap with largest acc
        run("R8 tbl wrap", 16'hFFFF, 2'd1, 2'd0, 16'h0000, 1'b0, 8'hFF);
        check16("R8 tbl wrap value", tbl_addr, 16'h00FF);

        // R9 hold while in_valid is low
        @(negedge clk);
        cur_pc = 16'h7777; kind = 2'd2; target = 16'h9999; take = 1'b1; acc = 8'h44;
        @(negedge clk);
        check16("R9 hold nxt_pc", nxt_pc, 16'h0000);
        check16("R9 hold tbl", tbl_addr, 16'h00FF);
        check16("R9 valid low", {15'd0, out_valid}, 16'd0);

        // Random mix, R2..R8
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] pc;
            logic [15:0] tg;
            logic [1:0]  ln;
            logic [1:0]  k;
            logic        t;
            logic [7:0]  a;
            pc = 16'($urandom());
            tg = 16'($urandom());
            ln = 2'($urandom());
            k  = 2'($urandom());
            t  = 1'($urandom());
            a  = 8'($urandom());
            if (i % 8 == 0) pc = {5'($urandom()), 11'h7FF} - 16'($urandom_range(0, 2));
            run("R2-model random", pc, ln, k, tg, t, a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule